// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns a two-channel serial audio stream into parallel left and right samples. Three inputs carry the stream: a bit clock, a word clock that marks the channel boundaries, and a serial data line that sends the most significant bit first. Every register in the block is clocked by the bit clock. The bit clock may stop between words and restart later, so the receiver never relies on a free-running bit counter. It measures each word from the word-clock transition that opens it.

A two-bit format selector picks one of four framings. I2S places the MSB one bit after the word-clock edge. Left-justified places the MSB on the edge itself. Right-justified places the LSB just before the next edge. DSP framing uses a one-bit sync pulse, followed by both channels back to back. A width input selects 18-bit or 16-bit words. Completed words appear on 18-bit outputs, each with its own one-cycle strobe. A sticky error flag reports a word boundary that arrives before the current word is complete.

Top module: `audio_ser_rx`

## Requirements
- R1: With wide_sel=1 a word is 18 bits. The first bit sampled for the word appears at bit 17 of the output and the last at bit 0, in twos complement.
- R2: With wide_sel=0 a word is 16 bits. It occupies output bits 17..2, and bits 1..0 read zero.
- R3: fmt_sel=01 (left-justified): a new word starts on the first bit-clock rising edge that samples a changed word-clock level. The bit sampled on that edge is the MSB. Word clock high means left.
- R4: fmt_sel=00 (I2S): the bit sampled on the changed-level edge is ignored, and the MSB is sampled on the next edge. Word clock low means left.
- R5: fmt_sel=10 (right-justified): on the edge that samples a changed word-clock level, the word is formed from the last N bits sampled before that edge, where N is the selected width. Extra leading bits are dropped. A previous level of high means left.
- R6: fmt_sel=11 (DSP): the sync is a word-clock sample of 1 that follows a sample of 0, and the data bit sampled with the sync is ignored. The left MSB is sampled on the next edge. The right word follows immediately after the left LSB. Bits after the right LSB are ignored until the next sync.
- R7: A channel's valid output is high for exactly one bit-clock cycle. That cycle follows the edge that sampled the word's last bit, or in right-justified mode the edge that saw the level change. The channel's data output changes only together with its valid.
- R8: frame_err is set when, in formats 00, 01 or 11, a word boundary or sync arrives while a started word is still incomplete. It stays set until reset and is never set in format 10.
- R9: An asynchronous low rst_n clears all outputs. After release, the reset takes two bit-clock edges to leave the block, and the third edge only records the word-clock level. No word starts before a later change of level.
- R10: Stopping the bit clock for any time between edges has no effect on the captured words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all sampling on its rising edge; may be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Word clock / frame sync |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP |
| wide_sel | input | 1 | 1 = 18-bit words, 0 = 16-bit words |
| left_word | output | 18 | Last completed left sample |
| right_word | output | 18 | Last completed right sample |
| left_vld | output | 1 | One-cycle strobe for a new left sample |
| right_vld | output | 1 | One-cycle strobe for a new right sample |
| frame_err | output | 1 | Sticky short-word flag |

## Verification
A bit counter that is off by one shows up at the ports in the same half-frame. The strobe moves by one cycle, or the captured word shifts by one bit, and the next strobe exposes it. A wrong channel polarity or a missed sync either swaps the two outputs or removes a strobe within one frame. A stale "word in progress" state is caught at the next boundary. It either raises the error flag on a well-formed stream or misses a short word that should have raised it. The bench recomputes every strobe, data value and error cycle from the stream it drives and compares on every bit-clock cycle.

// File: rtl/audio_ser_rx_pkg.sv
`timescale 1ns/1ps
package audio_ser_rx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  localparam int unsigned DEF_WORD_W   = 18;
  localparam int unsigned DEF_NARROW_W = 16;
  localparam int unsigned DEF_SYNC_STG = 2;
endpackage

// File: rtl/audio_ser_rx_rst_sync.sv
`timescale 1ns/1ps
module audio_ser_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stg_q <= '0;
    else          stg_q <= stg_d;
  end

  assign rst_no = stg_q[STAGES-1];
endmodule

// File: rtl/audio_ser_rx_lr_track.sv
`timescale 1ns/1ps
module audio_ser_rx_lr_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lr_i,
  output logic lr_prev_o,
  output logic lr_flip_o,
  output logic lr_rise_o
);
  logic lr_q, lr_d;
  logic primed_q, primed_d;

  always_comb begin
    lr_d      = lr_i;
    primed_d  = 1'b1;
    lr_flip_o = primed_q && (lr_i != lr_q);
    lr_rise_o = primed_q && lr_i && !lr_q;
    lr_prev_o = lr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q     <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lr_q     <= lr_d;
      primed_q <= primed_d;
    end
  end
endmodule

// File: rtl/audio_ser_rx_word_ctl.sv
`timescale 1ns/1ps
module audio_ser_rx_word_ctl
  import audio_ser_rx_pkg::*;
#(
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned NARROW_W = DEF_NARROW_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] fmt_i,
  input  logic       wide_i,
  input  logic       lr_i,
  input  logic       lr_prev_i,
  input  logic       lr_flip_i,
  input  logic       lr_rise_i,
  output logic       shift_en_o,
  output logic       take_cur_o,
  output logic       done_o,
  output logic       done_left_o,
  output logic       err_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] NAR_N  = CNT_W'(NARROW_W);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  fmt_e             fmt;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, need_n;
  logic             active_q, active_d;
  logic             left_q, left_d;
  logic             err_q, err_d, err_set;
  logic             collect;

  always_comb begin
    fmt         = fmt_e'(fmt_i);
    need_n      = wide_i ? FULL_N : NAR_N;
    cnt_inc     = cnt_q + ONE;
    collect     = active_q && (cnt_q < need_n);
    cnt_d       = cnt_q;
    active_d    = active_q;
    left_d      = left_q;
    shift_en_o  = 1'b0;
    take_cur_o  = 1'b0;
    done_o      = 1'b0;
    done_left_o = left_q;
    err_set     = 1'b0;
    unique case (fmt)
      FMT_LJ: begin
        if (lr_flip_i) begin
          err_set    = collect;
          active_d   = 1'b1;
          left_d     = lr_i;
          shift_en_o = 1'b1;
          cnt_d      = ONE;
        end else if (collect) begin
          shift_en_o = 1'b1;
          cnt_d      = cnt_inc;
          done_o     = (cnt_inc == need_n);
        end
      end
      FMT_I2S: begin
        if (lr_flip_i) begin
          err_set  = collect;
          active_d = 1'b1;
          left_d   = !lr_i;
          cnt_d    = '0;
        end else if (collect) begin
          shift_en_o = 1'b1;
          cnt_d      = cnt_inc;
          done_o     = (cnt_inc == need_n);
        end
      end
      FMT_DSP: begin
        if (lr_rise_i) begin
          err_set  = active_q && (left_q || (cnt_q < need_n));
          active_d = 1'b1;
          left_d   = 1'b1;
          cnt_d    = '0;
        end else if (collect) begin
          shift_en_o = 1'b1;
          cnt_d      = cnt_inc;
          if (cnt_inc == need_n) begin
            done_o = 1'b1;
            if (left_q) begin
              left_d = 1'b0;
              cnt_d  = '0;
            end
          end
        end
      end
      FMT_RJ: begin
        shift_en_o  = 1'b1;
        take_cur_o  = 1'b1;
        done_o      = lr_flip_i;
        done_left_o = lr_prev_i;
      end
    endcase
    err_d = err_q || err_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      left_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      left_q   <= left_d;
      err_q    <= err_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/audio_ser_rx_capture.sv
`timescale 1ns/1ps
module audio_ser_rx_capture
  import audio_ser_rx_pkg::*;
#(
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned NARROW_W = DEF_NARROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              wide_i,
  input  logic              shift_en_i,
  input  logic              take_cur_i,
  input  logic              done_i,
  input  logic              done_left_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              left_vld_o,
  output logic              right_vld_o
);
  localparam int unsigned PAD_W = WORD_W - NARROW_W;

  logic [WORD_W-1:0] sh_q, sh_d, sh_nxt, word, narrow_al, aligned;
  logic [WORD_W-1:0] left_q, left_d, right_q, right_d;
  logic              lv_q, lv_d, rv_q, rv_d;
  logic              load_l, load_r;

  generate
    if (PAD_W > 0) begin : g_pad
      assign narrow_al = {word[NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign narrow_al = word;
    end
  endgenerate

  always_comb begin
    sh_nxt  = {sh_q[WORD_W-2:0], sdata_i};
    sh_d    = shift_en_i ? sh_nxt : sh_q;
    word    = take_cur_i ? sh_q : sh_nxt;
    aligned = wide_i ? word : narrow_al;
    load_l  = done_i && done_left_i;
    load_r  = done_i && !done_left_i;
    left_d  = load_l ? aligned : left_q;
    right_d = load_r ? aligned : right_q;
    lv_d    = load_l;
    rv_d    = load_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      right_q <= '0;
      lv_q    <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      left_q  <= left_d;
      right_q <= right_d;
      lv_q    <= lv_d;
      rv_q    <= rv_d;
    end
  end

  assign left_o      = left_q;
  assign right_o     = right_q;
  assign left_vld_o  = lv_q;
  assign right_vld_o = rv_q;
endmodule

// File: rtl/audio_ser_rx.sv
`timescale 1ns/1ps
module audio_ser_rx
  import audio_ser_rx_pkg::*;
#(
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned NARROW_W = DEF_NARROW_W,
  parameter int unsigned SYNC_STG = DEF_SYNC_STG
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              lrclk,
  input  logic              sdata,
  input  logic [1:0]        fmt_sel,
  input  logic              wide_sel,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              left_vld,
  output logic              right_vld,
  output logic              frame_err
);
  logic rst_int_n;
  logic lr_prev, lr_flip, lr_rise;
  logic shift_en, take_cur, done, done_left;

  audio_ser_rx_rst_sync #(.STAGES(SYNC_STG)) rst_i (
    .clk_i(bclk), .arst_ni(rst_n), .rst_no(rst_int_n)
  );

  audio_ser_rx_lr_track lr_i (
    .clk_i(bclk), .rst_ni(rst_int_n), .lr_i(lrclk),
    .lr_prev_o(lr_prev), .lr_flip_o(lr_flip), .lr_rise_o(lr_rise)
  );

  audio_ser_rx_word_ctl #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) ctl_i (
    .clk_i(bclk), .rst_ni(rst_int_n), .fmt_i(fmt_sel), .wide_i(wide_sel),
    .lr_i(lrclk), .lr_prev_i(lr_prev), .lr_flip_i(lr_flip), .lr_rise_i(lr_rise),
    .shift_en_o(shift_en), .take_cur_o(take_cur), .done_o(done),
    .done_left_o(done_left), .err_o(frame_err)
  );

  audio_ser_rx_capture #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) cap_i (
    .clk_i(bclk), .rst_ni(rst_int_n), .sdata_i(sdata), .wide_i(wide_sel),
    .shift_en_i(shift_en), .take_cur_i(take_cur), .done_i(done),
    .done_left_i(done_left), .left_o(left_word), .right_o(right_word),
    .left_vld_o(left_vld), .right_vld_o(right_vld)
  );
endmodule

// File: rtl/audio_ser_rx_checker.sv
`timescale 1ns/1ps
module audio_ser_rx_checker #(
  parameter int unsigned WORD_W   = 18,
  parameter int unsigned NARROW_W = 16
) (
  input logic              bclk,
  input logic              rst_n,
  input logic [1:0]        fmt_sel,
  input logic              wide_sel,
  input logic [WORD_W-1:0] left_word,
  input logic [WORD_W-1:0] right_word,
  input logic              left_vld,
  input logic              right_vld,
  input logic              frame_err
);
  AST_LVLD_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n) left_vld |=> !left_vld); // R7
  AST_RVLD_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n) right_vld |=> !right_vld); // R7
  AST_LDATA_HOLD: assert property (@(posedge bclk) disable iff (!rst_n) !$stable(left_word) |-> left_vld); // R7
  AST_RDATA_HOLD: assert property (@(posedge bclk) disable iff (!rst_n) !$stable(right_word) |-> right_vld); // R7
  AST_ERR_STICKY: assert property (@(posedge bclk) disable iff (!rst_n) frame_err |=> frame_err); // R8
  AST_RJ_NO_ERR: assert property (@(posedge bclk) disable iff (!rst_n) (fmt_sel == 2'b10 && !frame_err) |=> !frame_err); // R8
  AST_NARROW_PAD: assert property (@(posedge bclk) disable iff (!rst_n) (left_vld && !$past(wide_sel)) |-> (left_word[WORD_W-NARROW_W-1:0] == '0)); // R2
endmodule

bind audio_ser_rx audio_ser_rx_checker #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) chk_i (
  .bclk(bclk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wide_sel(wide_sel),
  .left_word(left_word), .right_word(right_word), .left_vld(left_vld),
  .right_vld(right_vld), .frame_err(frame_err)
);

// File: tb/audio_ser_rx_tb_top.sv
`timescale 1ns/1ps
module audio_ser_rx_tb_top;
  logic        bclk = 1'b0, rst_n = 1'b0, lrclk = 1'b0, sdata = 1'b0, wide = 1'b1;
  logic [1:0]  fmt = 2'b00;
  logic [17:0] lw, rw;
  logic        lv, rv, ferr;

  int    checks = 0, errors = 0, tickn = 0, gap_every = 0;
  bit    finished = 1'b0;
  string req = "R9";
  logic [17:0] exp_l = '0, exp_r = '0, hist = '0;
  logic        exp_err = 1'b0;
  logic [17:0] lval_at[int];
  logic [17:0] rval_at[int];
  bit          err_at[int];

  audio_ser_rx dut_i (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata), .fmt_sel(fmt),
    .wide_sel(wide), .left_word(lw), .right_word(rw), .left_vld(lv),
    .right_vld(rv), .frame_err(ferr)
  );

  function automatic logic [17:0] align(input logic [17:0] v);
    return wide ? v : {v[15:0], 2'b00};
  endfunction

  function automatic int nw();
    return wide ? 18 : 16;
  endfunction

  task automatic chk1(input string what, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s tick %0d actual %h expected %h", req, what, tickn, act, exp);
    end
  endtask

  task automatic compare();
    logic el, er;
    el = lval_at.exists(tickn);
    er = rval_at.exists(tickn);
    if (el) exp_l = lval_at[tickn];
    if (er) exp_r = rval_at[tickn];
    if (err_at.exists(tickn)) exp_err = 1'b1;
    chk1("left_vld",   {17'b0, lv},   {17'b0, el});
    chk1("right_vld",  {17'b0, rv},   {17'b0, er});
    chk1("left_word",  lw, exp_l);
    chk1("right_word", rw, exp_r);
    chk1("frame_err",  {17'b0, ferr}, {17'b0, exp_err});
  endtask

  // one bit-clock period of 5 ns (200 MHz), inputs set while bclk is low
  task automatic tick(input logic lr, input logic d);
    lrclk = lr;
    sdata = d;
    #2.5 bclk = 1'b1;
    tickn++;
    hist = {hist[16:0], d};
    #1.25 compare();
    #1.25 bclk = 1'b0;
  endtask

  // rep: 0 none, 1 left strobe on last data bit, 2 right strobe on last data bit
  task automatic half(input logic lr, input int lead, input logic [17:0] val,
                      input int trail, input int rep);
    for (int i = 0; i < lead; i++) tick(lr, 1'b0);
    for (int i = nw() - 1; i >= 0; i--) begin
      if (gap_every > 0 && (i % gap_every) == 0) #40;
      if (i == 0 && rep == 1) lval_at[tickn + 1] = align(val);
      if (i == 0 && rep == 2) rval_at[tickn + 1] = align(val);
      tick(lr, val[i]);
    end
    for (int i = 0; i < trail; i++) tick(lr, 1'b0);
  endtask

  task automatic rj_report(input bit is_left);
    if (is_left) lval_at[tickn + 1] = wide ? hist : {hist[15:0], 2'b00};
    else         rval_at[tickn + 1] = wide ? hist : {hist[15:0], 2'b00};
  endtask

  task automatic dsp_frame(input logic [17:0] l, input logic [17:0] r, input int pad);
    tick(1'b1, 1'b1);
    half(1'b0, 0, l, 0, 1);
    half(1'b0, 0, r, 0, 2);
    for (int i = 0; i < pad; i++) tick(1'b0, 1'b1);
  endtask

  task automatic do_reset(input logic [1:0] f, input logic w, input logic prime_lr);
    req = "R9";
    rst_n = 1'b0;
    fmt = f;
    wide = w;
    exp_l = '0; exp_r = '0; exp_err = 1'b0;
    lval_at.delete(); rval_at.delete(); err_at.delete();
    tick(prime_lr, 1'b0);
    tick(prime_lr, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(prime_lr, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s tick %0d actual hung expected done", req, tickn);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // left-justified, 18 bit
    do_reset(2'b01, 1'b1, 1'b1);
    req = "R3 R1 R7";
    half(1'b0, 0, 18'h2A5C3, 2, 2);
    half(1'b1, 0, 18'h1F00F, 2, 1);
    half(1'b0, 0, 18'h30001, 0, 2);
    half(1'b1, 0, 18'h3FFFF, 3, 1);
    req = "R8";
    half(1'b0, 0, 18'h0ABCD, 0, 2);
    for (int i = 0; i < 9; i++) tick(1'b1, 1'b1);
    err_at[tickn + 1] = 1'b1;
    half(1'b0, 0, 18'h20000, 1, 2);
    half(1'b1, 0, 18'h13579, 1, 1);
    tick(1'b0, 1'b0);

    // left-justified, 16 bit, gated bit clock
    do_reset(2'b01, 1'b0, 1'b1);
    req = "R10 R2";
    gap_every = 5;
    half(1'b0, 0, 18'h0BEEF, 1, 2);
    half(1'b1, 0, 18'h08001, 0, 1);
    half(1'b0, 0, 18'h07FFF, 2, 2);
    gap_every = 0;
    tick(1'b1, 1'b0);

    // I2S, 18 bit
    do_reset(2'b00, 1'b1, 1'b1);
    req = "R4";
    half(1'b0, 1, 18'h155AA, 0, 1);
    half(1'b1, 1, 18'h2AA55, 2, 2);
    half(1'b0, 1, 18'h3C3C3, 3, 1);
    half(1'b1, 1, 18'h00001, 0, 2);
    tick(1'b0, 1'b1);

    // right-justified, 16 bit
    do_reset(2'b10, 1'b0, 1'b1);
    req = "R5";
    half(1'b1, 2, 18'h0A1B2, 0, 0); rj_report(1'b1);
    half(1'b0, 0, 18'h0FFFE, 0, 0); rj_report(1'b0);
    half(1'b1, 5, 18'h08000, 0, 0); rj_report(1'b1);
    req = "R5 R8";
    tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b0, 1'b1); tick(1'b0, 1'b1);
    rj_report(1'b0);
    half(1'b1, 0, 18'h01234, 0, 0); rj_report(1'b1);
    tick(1'b0, 1'b0);

    // right-justified, 18 bit
    do_reset(2'b10, 1'b1, 1'b1);
    req = "R5 R1";
    half(1'b1, 0, 18'h2DEAD, 0, 0); rj_report(1'b1);
    half(1'b0, 3, 18'h1BEEF, 0, 0); rj_report(1'b0);
    tick(1'b1, 1'b0);

    // DSP, 18 bit
    do_reset(2'b11, 1'b1, 1'b0);
    req = "R6";
    dsp_frame(18'h3A5A5, 18'h05A5A, 3);
    dsp_frame(18'h00F0F, 18'h3F0F0, 0);
    req = "R6 R8";
    tick(1'b1, 1'b1);
    half(1'b0, 0, 18'h11111, 0, 1);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
    err_at[tickn + 1] = 1'b1;
    dsp_frame(18'h22222, 18'h33333, 2);

    // DSP, 16 bit
    do_reset(2'b11, 1'b0, 1'b0);
    req = "R6 R2";
    dsp_frame(18'h0C001, 18'h07FFE, 1);
    dsp_frame(18'h0FFFF, 18'h00000, 2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule